// File: doc/BRIEF.md
# Segmented Operand Additive Multiplier

This block multiplies two unsigned 8-bit operands and delivers the exact 16-bit product one clock later. It does not build eight single-bit partial-product rows. It cuts the multiplicand into two 4-bit nibbles and the multiplier into four 2-bit groups. It then forms all eight nibble-by-group products at the same time, each 6 bits wide, and places each one at its binary weight. The weighted terms are added in two levels. The first level combines the two nibble terms of each group. The second level adds the four group sums at their group weights.

A request is presented by raising `in_valid` with both operands. On the next rising clock edge the product register loads the result and `prod_valid` rises. Cycles without `in_valid` leave the product register unchanged.

Top module: `segmul_top`

## Requirements
- R1: On every rising edge where `rst_n` is high and `in_valid` is high, `prod` loads the exact unsigned product `op_a * op_b`. This holds for all 65536 operand pairs.
- R2: `prod_valid` is high in the cycle after an edge that sampled `in_valid` high. It is low in the cycle after an edge that sampled `in_valid` low.
- R3: A rising edge with `rst_n` low clears `prod` to 0 and `prod_valid` to 0, whatever the other inputs are. This applies both at start-up and in the middle of a stream.
- R4: A rising edge with `rst_n` high and `in_valid` low leaves `prod` unchanged, even when the operands change.
- R5: The multiplicand is treated as a high nibble (bits 7..4, weight 16) plus a low nibble (bits 3..0, weight 1). An operand A with only the high nibble nonzero gives 16 times the product of that nibble and B.
- R6: The multiplier is treated as four 2-bit groups. Bits 1..0 have weight 1, bits 3..2 weight 4, bits 5..4 weight 16 and bits 7..6 weight 64. A B value with only one group nonzero gives A times that group value times the group weight.
- R7: The corner cases give the expected results: 0 times anything is 0, 1 times 1 is 1, and 255 times 255 is 65025. No product ever exceeds 65025.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands are valid this cycle |
| op_a | input | 8 | Unsigned multiplicand |
| op_b | input | 8 | Unsigned multiplier |
| prod | output | 16 | Registered product |
| prod_valid | output | 1 | Product register holds a new result |

## Verification
The hardest condition to reach from the ports is a carry that crosses nibble and group boundaries in the final sum. This only happens when several of the eight segment terms are large at once, and it is easy to miss with sparse patterns. The stimulus therefore walks through every operand pair, plus the single-group and high-nibble-only patterns that isolate each term's weight. It also mixes idle cycles with changing operands and a reset in the middle of the stream, so that hold and clear behaviour are seen between real results.

// File: rtl/segmul_pkg.sv
// Package: shared widths for the segmented multiplier.
// Assumes unsigned operands; every derived width follows from the parameters.
package segmul_pkg;
    parameter int A_W   = 8;                 // multiplicand width
    parameter int B_W   = 8;                 // multiplier width
    parameter int SEG_W = 4;                 // multiplicand nibble width
    parameter int GRP_W = 2;                 // multiplier group width
    localparam int N_SEG  = A_W / SEG_W;     // multiplicand segments
    localparam int N_GRP  = B_W / GRP_W;     // multiplier groups
    localparam int PP_W   = SEG_W + GRP_W;   // one segment product
    localparam int GSUM_W = A_W + GRP_W;     // one group sum
    localparam int P_W    = A_W + B_W;       // full product
endpackage

// File: rtl/segmul_pp_cell.sv
// Module: one nibble-by-group product.
// Forms seg * grp by gated shifted copies of seg; assumes grp is GRP_W bits.
module segmul_pp_cell
    import segmul_pkg::*;
(
    input  logic [SEG_W-1:0] seg,
    input  logic [GRP_W-1:0] grp,
    output logic [PP_W-1:0]  pp
);
    // Add one shifted copy of seg per set bit of grp.
    always_comb begin
        pp = '0;
        for (int k = 0; k < GRP_W; k++) begin
            if (grp[k]) pp = pp + (PP_W'(seg) << k);
        end
    end
endmodule

// File: rtl/segmul_group_sum.sv
// Module: first tree level for one multiplier group.
// Adds the weighted nibble products of one group; assumes N_SEG terms in.
module segmul_group_sum
    import segmul_pkg::*;
(
    input  logic [N_SEG*PP_W-1:0] pps,
    output logic [GSUM_W-1:0]     gsum
);
    // Place each nibble product at its nibble weight and add them.
    always_comb begin
        gsum = '0;
        for (int s = 0; s < N_SEG; s++) begin
            gsum = gsum + (GSUM_W'(pps[s*PP_W +: PP_W]) << (s*SEG_W));
        end
    end
endmodule

// File: rtl/segmul_final_sum.sv
// Module: second tree level.
// Adds the group sums at group weights; assumes the sum fits in P_W bits.
module segmul_final_sum
    import segmul_pkg::*;
(
    input  logic [N_GRP*GSUM_W-1:0] gsums,
    output logic [P_W-1:0]          total
);
    // Place each group sum at its group weight and add them.
    always_comb begin
        total = '0;
        for (int g = 0; g < N_GRP; g++) begin
            total = total + (P_W'(gsums[g*GSUM_W +: GSUM_W]) << (g*GRP_W));
        end
    end
endmodule

// File: rtl/segmul_top.sv
// Module: segmented operand additive multiplier, one output register stage.
// Splits op_a into nibbles and op_b into 2-bit groups, makes all segment
// products in parallel, and sums them in two levels. Reset is synchronous, active low.
module segmul_top
    import segmul_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [A_W-1:0] op_a,
    input  logic [B_W-1:0] op_b,
    output logic [P_W-1:0] prod,
    output logic           prod_valid
);
    logic [N_SEG*PP_W-1:0]   pp_bus [N_GRP];
    logic [N_GRP*GSUM_W-1:0] gsum_bus;
    logic [P_W-1:0]          total;

    // One product cell per (group, nibble) pair, one group adder per group.
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        for (genvar s = 0; s < N_SEG; s++) begin : g_seg
            segmul_pp_cell u_cell (
                .seg (op_a[s*SEG_W +: SEG_W]),
                .grp (op_b[g*GRP_W +: GRP_W]),
                .pp  (pp_bus[g][s*PP_W +: PP_W])
            );
        end
        segmul_group_sum u_gsum (
            .pps  (pp_bus[g]),
            .gsum (gsum_bus[g*GSUM_W +: GSUM_W])
        );
    end

    segmul_final_sum u_final (
        .gsums (gsum_bus),
        .total (total)
    );

    // Output stage: load the sum on valid input, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod       <= '0;
            prod_valid <= 1'b0;
        end else begin
            prod_valid <= in_valid;
            if (in_valid) prod <= total;
        end
    end
endmodule

// File: rtl/segmul_checker.sv
// Module: protocol and result checks for segmul_top, bound to every instance.
module segmul_checker
    import segmul_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [A_W-1:0] op_a,
    input logic [B_W-1:0] op_b,
    input logic [P_W-1:0] prod,
    input logic           prod_valid
);
    AST_PRODUCT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> prod == P_W'($past(op_a)) * P_W'($past(op_b))); // R1
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> prod_valid); // R2
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !prod_valid); // R2
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (prod == '0 && !prod_valid)); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(prod)); // R4
    AST_PRODUCT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        prod <= P_W'(65025)); // R7
endmodule

bind segmul_top segmul_checker u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a),
    .op_b(op_b), .prod(prod), .prod_valid(prod_valid)
);

// File: tb/tb_segmul_top.sv
// Bench: behavioural reference updated each edge, compared every clock.
module tb_segmul_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  op_a = '0;
    logic [7:0]  op_b = '0;
    logic [15:0] prod;
    logic        prod_valid;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    exp_prod = 0;
    bit    exp_valid = 1'b0;
    string cur_tag = "R3";
    string exp_tag = "R3";
    bit    checking = 1'b0;

    always #2.5 clk = ~clk;

    segmul_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a),
        .op_b(op_b), .prod(prod), .prod_valid(prod_valid)
    );

    // Reference: integer multiply, captured at each rising edge.
    always @(posedge clk) begin
        exp_tag <= cur_tag;
        if (!rst_n) begin
            exp_prod  <= 0;
            exp_valid <= 1'b0;
        end else begin
            exp_valid <= in_valid;
            if (in_valid) exp_prod <= int'(op_a) * int'(op_b);
        end
    end

    // Compare at the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (checking) begin
            n_cmp++;
            if (int'(prod) != exp_prod) begin
                n_bad++;
                $display("FAIL %s prod actual=%0d expected=%0d", exp_tag, prod, exp_prod);
            end
            n_cmp++;
            if (prod_valid != exp_valid) begin
                n_bad++;
                $display("FAIL R2 prod_valid actual=%0b expected=%0b", prod_valid, exp_valid);
            end
        end
    end

    task automatic drive(input bit v, input int a, input int b, input string tag);
        @(negedge clk);
        in_valid = v;
        op_a     = 8'(a);
        op_b     = 8'(b);
        cur_tag  = tag;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checking = 1'b1;            // reset state compared (R3)
        drive(1, 0, 0, "R3");
        rst_n = 1'b1;
        drive(1, 0, 0, "R7");
        drive(1, 0, 255, "R7");
        drive(1, 1, 1, "R7");
        drive(1, 255, 255, "R7");
        drive(1, 255, 0, "R7");
        for (int g = 0; g < 4; g++) begin
            for (int v = 1; v < 4; v++) begin
                drive(1, 8'hAB, v << (2 * g), "R6");
                drive(1, 255, v << (2 * g), "R6");
            end
        end
        for (int h = 1; h < 16; h++) drive(1, h << 4, 8'hC7, "R5");
        drive(1, 200, 201, "R4");
        for (int i = 0; i < 6; i++) drive(0, i * 37, 255 - i, "R4");
        drive(1, 77, 99, "R3");
        @(negedge clk);
        rst_n = 1'b0;
        cur_tag = "R3";
        drive(1, 250, 250, "R3");
        drive(0, 250, 250, "R3");
        rst_n = 1'b1;
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                drive(((a + b) % 11) != 0, a, b, "R1");
            end
        end
        drive(0, 0, 0, "R4");
        repeat (2) @(negedge clk);
        checking = 1'b0;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule